// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel behind an 8-bit host write port. The host selects an operating mode through a command register, then writes a 16-bit divisor into the channel data register as two bytes, low byte first. Once both bytes are in, the counter decrements on every cycle in which the slow tick enable is high. It drives a waveform output and a one-clock interrupt pulse according to the mode.

Three modes are offered. The one-shot mode raises the output once, after the divisor's worth of ticks. The rate-generator mode repeats every divisor ticks with a one-tick low pulse. The square-wave mode repeats with the output high for the upper half of the count and low for the lower half. With the customary 1.193182 MHz tick, a divisor of 11931 gives roughly a 100 Hz interrupt rate.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset, `tmr_out` and `tmr_irq` are low and the counter is idle, so ticks have no effect until a divisor is written.
- R2: A command write (`wr_cmd`=1) is accepted only when bits [5:4] equal 2'b11 and bits [3:1] name a mode: 3'b000 one-shot, 3'b010 or 3'b110 rate generator, 3'b011 or 3'b111 square wave. Any other command is ignored and leaves counting, output and byte pointer unchanged.
- R3: An accepted command stops counting and points the byte pointer at the low byte. The output becomes low for one-shot and high for the periodic modes.
- R4: The first data write after a command stores the divisor's low byte and the second stores the high byte. The second write starts counting with the full divisor, and a single byte starts nothing.
- R5: The counter moves only in clock cycles where `tick` is high; any number of cycles without a tick leaves the output and interrupt unchanged.
- R6: A divisor of 0 counts as 65536 ticks.
- R7: One-shot with divisor N: the output stays low for N-1 ticks and goes high at the N-th tick. An interrupt pulse comes with that tick, and then the output stays high with no further interrupts.
- R8: Rate generator with divisor N>=2: the period is N ticks. The output is low only between tick N-1 and tick N of each period, and an interrupt comes with each N-th tick.
- R9: Square wave with divisor N: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, so an odd N makes the high half one tick longer. An interrupt comes at each period's end, and N=1 holds the output high with an interrupt every tick.
- R10: `tmr_irq` is high for exactly one clock cycle, the one right after the clock edge that sampled the period-ending tick.
- R11: `tmr_out` changes at the clock edge that samples the tick (or the write) causing the change, through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick enable, one clock wide per count |
| wr_en | input | 1 | Host write strobe |
| wr_cmd | input | 1 | 1 selects the command register, 0 the channel data register |
| wr_data | input | 8 | Host write data |
| tmr_out | output | 1 | Waveform output |
| tmr_irq | output | 1 | Interrupt pulse, one clock wide |

## Verification
Every cycle, the assertions check these properties: interrupts come only from a tick while counting, the counter holds still while idle, a command stops counting and rewinds the byte pointer, the second byte arms the counter, a one-shot interrupt leaves the output high and stopped, and a square-wave output rises only at a period boundary. The exact waveform shapes (one-shot delay, rate-generator low slot, uneven square-wave halves) can be shown only by the bench's scenarios. The same holds for byte order on a divisor above 255, the 65536 case for divisor 0, and commands that must be ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_RATE    = 2'd2,
        MODE_SQUARE  = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] ACC_LOHI = 2'b11;
endpackage

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_cmd,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  cmd_stb,
    output tmr_mode_e             cmd_mode,
    output logic                  load_stb,
    output logic [2*DATA_W:0]     load_div
);
    localparam int DIV_W = 2 * DATA_W;
    localparam int EXT_W = DIV_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic              hi_next;
    } host_st_t;

    host_st_t st_d, st_q;
    logic     mode_ok;
    logic     data_wr;
    logic [DIV_W-1:0] raw_div;

    always_comb begin
        mode_ok  = 1'b1;
        cmd_mode = MODE_ONESHOT;
        case (wr_data[3:1])
            3'b000:         cmd_mode = MODE_ONESHOT;
            3'b010, 3'b110: cmd_mode = MODE_RATE;
            3'b011, 3'b111: cmd_mode = MODE_SQUARE;
            default:        mode_ok  = 1'b0;
        endcase

        cmd_stb  = wr_en && wr_cmd && (wr_data[5:4] == ACC_LOHI) && mode_ok;
        data_wr  = wr_en && !wr_cmd;
        load_stb = data_wr && st_q.hi_next;
        raw_div  = {wr_data, st_q.lo};
        load_div = (raw_div == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, raw_div};

        st_d = st_q;
        if (cmd_stb) begin
            st_d.hi_next = 1'b0;
        end else if (data_wr) begin
            if (!st_q.hi_next) begin
                st_d.lo      = wr_data;
                st_d.hi_next = 1'b1;
            end else begin
                st_d.hi_next = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    low_byte_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !st_q.hi_next) |=> st_q.hi_next);

    // R3
    cmd_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !st_q.hi_next);

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (load_div != '0) && (load_div <= (EXT_W'(1) << DIV_W)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int EXT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_stb,
    input  tmr_mode_e        cmd_mode,
    input  logic             load_stb,
    input  logic [EXT_W-1:0] load_div,
    output logic             out_o,
    output logic             irq_o
);
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    typedef struct packed {
        tmr_mode_e        mode;
        logic             run;
        logic             phase_lo;
        logic [EXT_W-1:0] cnt;
        logic [EXT_W-1:0] reload;
        logic             out;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;

    function automatic logic [EXT_W-1:0] half_up(input logic [EXT_W-1:0] v);
        return (v >> 1) + {{(EXT_W-1){1'b0}}, v[0]};
    endfunction

    function automatic logic [EXT_W-1:0] half_dn(input logic [EXT_W-1:0] v);
        return v >> 1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cmd_stb) begin
            st_d.mode     = cmd_mode;
            st_d.run      = 1'b0;
            st_d.phase_lo = 1'b0;
            st_d.cnt      = '0;
            st_d.out      = (cmd_mode != MODE_ONESHOT);
        end else if (load_stb) begin
            st_d.run      = 1'b1;
            st_d.phase_lo = 1'b0;
            st_d.reload   = load_div;
            case (st_q.mode)
                MODE_RATE: begin
                    st_d.cnt = load_div;
                    st_d.out = (load_div != ONE);
                end
                MODE_SQUARE: begin
                    st_d.cnt = half_up(load_div);
                    st_d.out = 1'b1;
                end
                default: begin
                    st_d.cnt = load_div;
                    st_d.out = 1'b0;
                end
            endcase
        end else if (st_q.run && tick) begin
            if (st_q.cnt == ONE) begin
                case (st_q.mode)
                    MODE_RATE: begin
                        st_d.cnt = st_q.reload;
                        st_d.out = (st_q.reload != ONE);
                        st_d.irq = 1'b1;
                    end
                    MODE_SQUARE: begin
                        if (!st_q.phase_lo && (half_dn(st_q.reload) != '0)) begin
                            st_d.phase_lo = 1'b1;
                            st_d.cnt      = half_dn(st_q.reload);
                            st_d.out      = 1'b0;
                        end else begin
                            st_d.phase_lo = 1'b0;
                            st_d.cnt      = half_up(st_q.reload);
                            st_d.out      = 1'b1;
                            st_d.irq      = 1'b1;
                        end
                    end
                    default: begin
                        st_d.run = 1'b0;
                        st_d.out = 1'b1;
                        st_d.irq = 1'b1;
                    end
                endcase
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                if (st_q.mode == MODE_RATE) begin
                    st_d.out = (st_d.cnt != ONE);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_ONESHOT, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;
    assign irq_o = st_q.irq;

    // R10
    irq_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(tick && st_q.run));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !cmd_stb && !load_stb) |=> $stable(st_q.cnt));

    // R4
    armed_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> st_q.run);

    // R3
    cmd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !st_q.run);

    // R7
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && st_q.mode == MODE_ONESHOT) |-> (st_q.out && !st_q.run));

    // R6
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt != '0));

    // R9
    sq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SQUARE && $rose(st_q.out) && !$past(load_stb) && !$past(cmd_stb))
            |-> st_q.irq);
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tmr_out,
    output logic              tmr_irq
);
    localparam int EXT_W = 2 * DATA_W + 1;

    logic             cmd_stb;
    tmr_mode_e        cmd_mode;
    logic             load_stb;
    logic [EXT_W-1:0] load_div;

    tmr_host_if #(.DATA_W(DATA_W)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .cmd_stb  (cmd_stb),
        .cmd_mode (cmd_mode),
        .load_stb (load_stb),
        .load_div (load_div)
    );

    tmr_count_core #(.EXT_W(EXT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_stb  (cmd_stb),
        .cmd_mode (cmd_mode),
        .load_stb (load_stb),
        .load_div (load_div),
        .out_o    (tmr_out),
        .irq_o    (tmr_irq)
    );

    // R1
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |=> !tmr_irq || $past(tick));
endmodule

// File: tb/test_interval_timer_chan.sv
module test_interval_timer_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tmr_out;
    logic       tmr_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  o;
        logic  i;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    interval_timer_chan i_interval_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit cmd, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_cmd = 1'b0;
    endtask

    // driver: queue the expected result, then pulse one tick
    task automatic tick_exp(input logic o, input logic i, input string req);
        @(negedge clk);
        sb_q.push_back('{o: o, i: i, req: req});
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // mode 0 one-shot, 2 rate, 3 square; ticks k0..k1 counted from the load
    task automatic run_model(input int mode, input int n, input int k0, input int k1, input string req);
        for (int k = k0; k <= k1; k++) begin
            int  r;
            logic o, i;
            r = k % n;
            if (mode == 0) begin
                o = (k >= n); i = (k == n);
            end else if (mode == 2) begin
                o = (r == 0) ? 1'b1 : (r != n - 1); i = (r == 0);
            end else begin
                o = (r == 0) ? 1'b1 : (r < (n + 1) / 2); i = (r == 0);
            end
            tick_exp(o, i, req);
        end
    endtask

    // long count with the tick held high; checks just before and at the end
    task automatic long_run(input int n, input string req);
        @(negedge clk);
        tick = 1'b1;
        repeat (n - 1) @(negedge clk);
        chk(tmr_out == 1'b0, req, tmr_out, 0);
        @(negedge clk);
        tick = 1'b0;
        chk(tmr_out == 1'b1 && tmr_irq == 1'b1, req, {tmr_out, tmr_irq}, 3);
        @(negedge clk);
        chk(tmr_irq == 1'b0, "R10", tmr_irq, 0);
    endtask

    // monitor: compare after each tick edge
    initial begin
        forever begin
            @(posedge clk);
            if (tick && sb_q.size() > 0) begin
                exp_t e;
                @(negedge clk);
                e = sb_q.pop_front();
                chk(tmr_out == e.o && tmr_irq == e.i, e.req, {tmr_out, tmr_irq}, {e.o, e.i});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, ticks ignored while idle
        chk(tmr_out == 1'b0 && tmr_irq == 1'b0, "R1", {tmr_out, tmr_irq}, 0);
        tick_exp(1'b0, 1'b0, "R1");

        // R3 / R7: one-shot, single byte does not start (R4)
        wr(1'b1, 8'h30);
        chk(tmr_out == 1'b0, "R3", tmr_out, 0);
        wr(1'b0, 8'd5);
        tick_exp(1'b0, 1'b0, "R4");
        wr(1'b0, 8'd0);
        run_model(0, 5, 1, 7, "R7");
        // R5: idle cycles change nothing
        repeat (20) @(negedge clk);
        chk(tmr_out == 1'b1 && tmr_irq == 1'b0, "R5", {tmr_out, tmr_irq}, 2);

        // R8: rate generator
        wr(1'b1, 8'h34);
        chk(tmr_out == 1'b1, "R3", tmr_out, 1);
        tick_exp(1'b1, 1'b0, "R4");
        wr(1'b0, 8'd4); wr(1'b0, 8'd0);
        run_model(2, 4, 1, 9, "R8");
        // R2: alias mode code 3'b110
        wr(1'b1, 8'h3C);
        wr(1'b0, 8'd3); wr(1'b0, 8'd0);
        run_model(2, 3, 1, 7, "R2");

        // R9: square wave, odd, even and N=1
        wr(1'b1, 8'h36);
        wr(1'b0, 8'd5); wr(1'b0, 8'd0);
        run_model(3, 5, 1, 10, "R9");
        wr(1'b1, 8'h36);
        wr(1'b0, 8'd1); wr(1'b0, 8'd0);
        run_model(3, 1, 1, 3, "R9");
        wr(1'b1, 8'h36);
        wr(1'b0, 8'd4); wr(1'b0, 8'd0);
        run_model(3, 4, 1, 3, "R9");
        // R2: ignored commands mid-count
        wr(1'b1, 8'h16);
        wr(1'b1, 8'h32);
        wr(1'b1, 8'h3A);
        chk(tmr_out == 1'b0, "R2", tmr_out, 0);
        run_model(3, 4, 4, 9, "R2");

        // R3 / R4: command between bytes rewinds the pointer
        wr(1'b1, 8'h34);
        wr(1'b0, 8'd7);
        wr(1'b1, 8'h34);
        wr(1'b0, 8'd3); wr(1'b0, 8'd0);
        run_model(2, 3, 1, 6, "R3");

        // R4: byte order with a divisor of 259
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h03); wr(1'b0, 8'h01);
        long_run(259, "R4");

        // R6: divisor 0 counts 65536
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h00); wr(1'b0, 8'h00);
        long_run(65536, "R6");

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R11", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule